// File: doc/BRIEF.md
# Timer Host Register Interface

This block sits between a byte-wide host bus and a bank of three down-counter channels. It decodes configuration words written to a shared control address into a per-channel setting: an operating mode, a binary or decimal count format, and a byte-access format. It turns byte writes on each channel's data address into a full 16-bit reload value with a one-cycle load strobe. On reads of a data address it returns the channel's live count one byte at a time, in the order that channel's access format sets.

A separate auxiliary register, selected by `aux_sel`, drives the gate of the last channel, holds a speaker-enable bit and reflects the last channel's output level. The gates of the other channels are tied high. The counters and any snapshot storage are outside this block. The block receives live counts on `cnt_in` and issues a latch-request pulse when the host asks for a snapshot.

Top module: `tmr_host_if`

## Requirements
- R1: After a synchronous reset, every channel reports mode 0, binary format and the two-byte access format. Both byte toggles expect the low byte, null-count is clear, no load or latch pulse is present, and the last channel's gate and the speaker enable are 0.
- R2: A write to address 3 with `aux_sel` low is a control word. Bits 7:6 pick the channel (00, 01, 10 = channels 0, 1, 2). Bits 5:4 give the access format (01 low only, 10 high only, 11 low then high). Bits 3:1 give the mode and bit 0 gives BCD (1) or binary (0). The channel's `ch_mode` and `ch_bcd` show the new values from the next cycle, and other channels keep theirs.
- R3: Mode codes 110 and 111 are stored as 010 and 011.
- R4: A control word with access format 00 raises `ch_latch` of the selected channel for exactly one cycle and leaves that channel's configuration and byte toggles unchanged.
- R5: A control word whose channel field is 11 changes no output.
- R6: A configuration word resets the channel's write and read toggles to the low byte and sets its `ch_null`. `ch_null` clears when that channel's load strobe is issued.
- R7: In low-only format a data write produces, in the next cycle, a one-cycle `ch_load_stb` with `ch_load_val` = {8'h00, byte}. In high-only format it produces {byte, 8'h00}.
- R8: In two-byte format the first data write produces no strobe. The second produces a strobe in the next cycle with `ch_load_val` = {second byte, first byte}.
- R9: A data-address read returns count bits 7:0 in low-only format and bits 15:8 in high-only format. In two-byte format it returns the low byte and the high byte in turn, and each `bus_rd` advances the read toggle.
- R10: With `aux_sel` low, a read of address 3 returns 8'h00.
- R11: An auxiliary write sets the last channel's gate from bit 0 and `spk_en` from bit 1. `ch_gate` of the other channels is always 1.
- R12: An auxiliary read returns the gate in bit 0, the speaker enable in bit 1, `out_last` in bit 5 and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_sel | input | 1 | Route the access to the auxiliary register |
| bus_addr | input | 2 | Register offset (0..2 data, 3 control) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cnt_in | input | NCH*16 | Live count of each channel |
| out_last | input | 1 | Output level of the last channel |
| ch_mode | output | NCH*3 | Mode per channel |
| ch_bcd | output | NCH | BCD select per channel |
| ch_load_stb | output | NCH | One-cycle reload strobe per channel |
| ch_load_val | output | NCH*16 | Reload value per channel |
| ch_null | output | NCH | Null-count flag per channel |
| ch_latch | output | NCH | One-cycle snapshot request per channel |
| ch_gate | output | NCH | Gate per channel |
| spk_en | output | 1 | Speaker enable |

## Verification
The bench builds the block with the default NCH of 3. This matches every channel code in the control word, and it leaves the fourth code, 11, unused, so the ignored-select case can be reached. With three channels the bench can interleave pair-mode writes on one channel with configuration of another. It can also cut a two-byte sequence off mid-way with a fresh control word, and it can mix reads and writes so the two toggles drift apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam logic [1:0] ADDR_CTRL = 2'd3;

    typedef enum logic [1:0] {
        FMT_LATCH = 2'b00,
        FMT_LO    = 2'b01,
        FMT_HI    = 2'b10,
        FMT_PAIR  = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [2:0] mode;
        logic       bcd;
        fmt_e       fmt;
    } ch_cfg_t;

    typedef struct packed {
        logic [1:0] sel;
        ch_cfg_t    cfg;
    } ctrl_word_t;

    localparam ch_cfg_t CFG_RESET = '{mode: 3'd0, bcd: 1'b0, fmt: FMT_PAIR};

    // Upper two mode codes alias onto the periodic modes.
    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return m[1] ? {1'b0, m[1:0]} : m;
    endfunction

    function automatic ctrl_word_t split_word(input logic [BYTE_W-1:0] w);
        ctrl_word_t c;
        c.sel      = w[7:6];
        c.cfg.fmt  = fmt_e'(w[5:4]);
        c.cfg.mode = fold_mode(w[3:1]);
        c.cfg.bcd  = w[0];
        return c;
    endfunction

endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NCH-1:0]    cfg_we,
    output logic [NCH-1:0]    latch_we,
    output ch_cfg_t           cfg_new
);
    ctrl_word_t cw;

    always_comb begin
        cw      = split_word(wdata);
        cfg_new = cw.cfg;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_hit
        logic hit;
        assign hit         = wr_ctrl && (cw.sel == 2'(g));
        assign cfg_we[g]   = hit && (cw.cfg.fmt != FMT_LATCH);
        assign latch_we[g] = hit && (cw.cfg.fmt == FMT_LATCH);
    end

    always_comb begin
        a_r2_single_target: assert ($countones(cfg_we | latch_we) <= 1)
            else $error("control word reached more than one channel");
    end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  ch_cfg_t           cfg_new,
    input  logic              latch_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_in,
    output ch_cfg_t           cfg,
    output logic [BYTE_W-1:0] rbyte,
    output logic              ld_stb,
    output logic [CNT_W-1:0]  ld_val,
    output logic              null_cnt,
    output logic              latch_pls
);
    logic              wtog;
    logic              rtog;
    logic [BYTE_W-1:0] lo_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= CFG_RESET;
            wtog      <= 1'b0;
            rtog      <= 1'b0;
            lo_hold   <= '0;
            ld_stb    <= 1'b0;
            ld_val    <= '0;
            null_cnt  <= 1'b0;
            latch_pls <= 1'b0;
        end else begin
            ld_stb    <= 1'b0;
            latch_pls <= latch_we;
            if (cfg_we) begin
                cfg      <= cfg_new;
                wtog     <= 1'b0;
                rtog     <= 1'b0;
                null_cnt <= 1'b1;
            end else begin
                if (data_we) begin
                    case (cfg.fmt)
                        FMT_LO: begin
                            ld_val   <= {{BYTE_W{1'b0}}, wdata};
                            ld_stb   <= 1'b1;
                            null_cnt <= 1'b0;
                        end
                        FMT_HI: begin
                            ld_val   <= {wdata, {BYTE_W{1'b0}}};
                            ld_stb   <= 1'b1;
                            null_cnt <= 1'b0;
                        end
                        FMT_PAIR: begin
                            if (!wtog) begin
                                lo_hold <= wdata;
                                wtog    <= 1'b1;
                            end else begin
                                ld_val   <= {wdata, lo_hold};
                                ld_stb   <= 1'b1;
                                wtog     <= 1'b0;
                                null_cnt <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
                if (data_re && cfg.fmt == FMT_PAIR)
                    rtog <= ~rtog;
            end
        end
    end

    always_comb begin
        case (cfg.fmt)
            FMT_LO:  rbyte = cnt_in[BYTE_W-1:0];
            FMT_HI:  rbyte = cnt_in[CNT_W-1:BYTE_W];
            default: rbyte = rtog ? cnt_in[CNT_W-1:BYTE_W] : cnt_in[BYTE_W-1:0];
        endcase
    end

    a_r6_toggles_cleared: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(cfg_we) |-> !wtog && !rtog && null_cnt)
        else $error("control word left a toggle set or null clear");

    a_r7_low_only_zero_high: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ld_stb && $past(cfg.fmt) == FMT_LO |-> ld_val[CNT_W-1:BYTE_W] == '0)
        else $error("low-only load has nonzero high byte");

    a_r8_pair_second_write: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ld_stb && $past(cfg.fmt) == FMT_PAIR |-> $past(wtog) && !wtog)
        else $error("pair load without a held low byte");

    a_r9_rtog_pair_only: assert property (@(posedge clk) disable iff (rst)
        cfg.fmt != FMT_PAIR |-> !rtog)
        else $error("read toggle moved outside two-byte format");

    a_r4_latch_keeps_cfg: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(latch_we) |-> $stable(cfg) && latch_pls)
        else $error("latch command disturbed configuration");
endmodule

// File: rtl/tmr_aux_reg.sv
module tmr_aux_reg
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              out_last,
    output logic              gate,
    output logic              spk_en,
    output logic [BYTE_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gate   <= 1'b0;
            spk_en <= 1'b0;
        end else if (we) begin
            gate   <= wdata[0];
            spk_en <= wdata[1];
        end
    end

    always_comb begin
        rdata    = '0;
        rdata[0] = gate;
        rdata[1] = spk_en;
        rdata[5] = out_last;
    end

    a_r11_gate_follows_write: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(we) |-> gate == $past(wdata[0]) && spk_en == $past(wdata[1]))
        else $error("auxiliary bits did not follow the write");
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 aux_sel,
    input  logic [1:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic [NCH*16-1:0]    cnt_in,
    input  logic                 out_last,
    output logic [NCH*3-1:0]     ch_mode,
    output logic [NCH-1:0]       ch_bcd,
    output logic [NCH-1:0]       ch_load_stb,
    output logic [NCH*16-1:0]    ch_load_val,
    output logic [NCH-1:0]       ch_null,
    output logic [NCH-1:0]       ch_latch,
    output logic [NCH-1:0]       ch_gate,
    output logic                 spk_en
);
    logic              wr_ctrl;
    logic [NCH-1:0]    cfg_we;
    logic [NCH-1:0]    latch_we;
    ch_cfg_t           cfg_new;
    logic [BYTE_W-1:0] chan_rb [NCH];
    logic [BYTE_W-1:0] aux_rb;
    logic              gate_last;

    assign wr_ctrl = bus_wr && !aux_sel && (bus_addr == ADDR_CTRL);

    tmr_cw_decode #(.NCH(NCH)) u_dec (
        .wr_ctrl (wr_ctrl),
        .wdata   (bus_wdata),
        .cfg_we  (cfg_we),
        .latch_we(latch_we),
        .cfg_new (cfg_new)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ch_cfg_t cfg;
        logic    data_we;
        logic    data_re;

        assign data_we = bus_wr && !aux_sel && (bus_addr == 2'(g));
        assign data_re = bus_rd && !aux_sel && (bus_addr == 2'(g));

        tmr_chan_port u_port (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (cfg_we[g]),
            .cfg_new  (cfg_new),
            .latch_we (latch_we[g]),
            .data_we  (data_we),
            .data_re  (data_re),
            .wdata    (bus_wdata),
            .cnt_in   (cnt_in[g*CNT_W +: CNT_W]),
            .cfg      (cfg),
            .rbyte    (chan_rb[g]),
            .ld_stb   (ch_load_stb[g]),
            .ld_val   (ch_load_val[g*CNT_W +: CNT_W]),
            .null_cnt (ch_null[g]),
            .latch_pls(ch_latch[g])
        );

        assign ch_mode[g*3 +: 3] = cfg.mode;
        assign ch_bcd[g]         = cfg.bcd;

        if (g == NCH - 1) begin : g_soft_gate
            assign ch_gate[g] = gate_last;
        end else begin : g_tied_gate
            assign ch_gate[g] = 1'b1;
        end
    end

    tmr_aux_reg u_aux (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_wr && aux_sel),
        .wdata   (bus_wdata),
        .out_last(out_last),
        .gate    (gate_last),
        .spk_en  (spk_en),
        .rdata   (aux_rb)
    );

    always_comb begin
        bus_rdata = '0;
        if (aux_sel) begin
            bus_rdata = aux_rb;
        end else begin
            for (int i = 0; i < NCH; i++)
                if (bus_addr == 2'(i)) bus_rdata = chan_rb[i];
        end
    end

    a_r10_ctrl_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !aux_sel && bus_addr == ADDR_CTRL |-> bus_rdata == 8'h00)
        else $error("control offset returned data");
endmodule

// File: tb/tmr_host_if_bench.sv
`timescale 1ns/1ps
module tmr_host_if_bench;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              aux_sel;
    logic [1:0]        bus_addr;
    logic              bus_wr;
    logic              bus_rd;
    logic [7:0]        bus_wdata;
    logic [7:0]        bus_rdata;
    logic [NCH*16-1:0] cnt_in;
    logic              out_last;
    logic [NCH*3-1:0]  ch_mode;
    logic [NCH-1:0]    ch_bcd;
    logic [NCH-1:0]    ch_load_stb;
    logic [NCH*16-1:0] ch_load_val;
    logic [NCH-1:0]    ch_null;
    logic [NCH-1:0]    ch_latch;
    logic [NCH-1:0]    ch_gate;
    logic              spk_en;

    always #2 clk = ~clk;

    tmr_host_if #(.NCH(NCH)) u_tmr_host_if (.*);

    // Reference state
    int m_mode [NCH];
    int m_bcd  [NCH];
    int m_fmt  [NCH];
    int m_wt   [NCH];
    int m_rt   [NCH];
    int m_lo   [NCH];
    int m_null [NCH];
    int m_stb  [NCH];
    int m_val  [NCH];
    int m_lat  [NCH];
    int m_gate;
    int m_spk;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_mode[c] = 0; m_bcd[c] = 0; m_fmt[c] = 3; m_wt[c] = 0; m_rt[c] = 0;
            m_lo[c] = 0; m_null[c] = 0; m_stb[c] = 0; m_val[c] = 0; m_lat[c] = 0;
        end
        m_gate = 0;
        m_spk  = 0;
    endtask

    function automatic int exp_rdata();
        int a = int'(bus_addr);
        int cnt;
        if (aux_sel) return (int'(out_last) << 5) | (m_spk << 1) | m_gate;
        if (a == 3) return 0;
        cnt = int'(cnt_in[a*16 +: 16]);
        if (m_fmt[a] == 1) return cnt & 8'hFF;
        if (m_fmt[a] == 2) return (cnt >> 8) & 8'hFF;
        return m_rt[a] ? ((cnt >> 8) & 8'hFF) : (cnt & 8'hFF);
    endfunction

    task automatic compare_all();
        chk("R9/R10/R12", "bus_rdata", int'(bus_rdata), exp_rdata());
        for (int c = 0; c < NCH; c++) begin
            chk("R2/R3", "ch_mode", int'(ch_mode[c*3 +: 3]), m_mode[c]);
            chk("R2", "ch_bcd", int'(ch_bcd[c]), m_bcd[c]);
            chk("R7/R8", "ch_load_stb", int'(ch_load_stb[c]), m_stb[c]);
            chk("R7/R8", "ch_load_val", int'(ch_load_val[c*16 +: 16]), m_val[c]);
            chk("R6", "ch_null", int'(ch_null[c]), m_null[c]);
            chk("R4", "ch_latch", int'(ch_latch[c]), m_lat[c]);
            chk("R11", "ch_gate", int'(ch_gate[c]), (c == NCH - 1) ? m_gate : 1);
        end
        chk("R11", "spk_en", int'(spk_en), m_spk);
    endtask

    task automatic model_step();
        int a = int'(bus_addr);
        int d = int'(bus_wdata);
        for (int c = 0; c < NCH; c++) begin
            m_stb[c] = 0;
            m_lat[c] = 0;
        end
        if (rst) begin
            model_reset();
            return;
        end
        if (bus_wr && aux_sel) begin
            m_gate = d & 1;
            m_spk  = (d >> 1) & 1;
        end else if (bus_wr && a == 3) begin
            int sel = (d >> 6) & 3;
            int fmt = (d >> 4) & 3;
            int md  = (d >> 1) & 7;
            if (sel < NCH) begin
                if (fmt == 0) m_lat[sel] = 1;
                else begin
                    if (md >= 6) md -= 4;
                    m_mode[sel] = md; m_bcd[sel] = d & 1; m_fmt[sel] = fmt;
                    m_wt[sel] = 0; m_rt[sel] = 0; m_null[sel] = 1;
                end
            end
        end else if (bus_wr && !aux_sel) begin
            if (m_fmt[a] == 1) begin
                m_val[a] = d; m_stb[a] = 1; m_null[a] = 0;
            end else if (m_fmt[a] == 2) begin
                m_val[a] = d << 8; m_stb[a] = 1; m_null[a] = 0;
            end else if (m_wt[a] == 0) begin
                m_lo[a] = d; m_wt[a] = 1;
            end else begin
                m_val[a] = (d << 8) | m_lo[a]; m_stb[a] = 1; m_wt[a] = 0; m_null[a] = 0;
            end
        end
        if (bus_rd && !aux_sel && a < NCH && m_fmt[a] == 3) m_rt[a] ^= 1;
    endtask

    task automatic cyc(input bit aux, input int addr, input bit wr, input bit rd, input int d);
        @(negedge clk);
        aux_sel = aux; bus_addr = 2'(addr); bus_wr = wr; bus_rd = rd; bus_wdata = 8'(d);
        #1;
        compare_all();
        @(posedge clk);
        model_step();
    endtask

    task automatic idle();
        cyc(1'b0, 0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        rst = 1'b1; aux_sel = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        out_last = 0;
        cnt_in = {16'h5A3C, 16'h9876, 16'hBEEF};
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        idle();
        // R2/R7: channel 1 low-only, mode 2, BCD
        cyc(0, 3, 1, 0, 8'h55);
        cyc(0, 1, 1, 0, 8'hAB);
        idle();
        // R7: channel 2 high-only, mode 3
        cyc(0, 3, 1, 0, 8'hA6);
        cyc(0, 2, 1, 0, 8'h12);
        idle();
        // R3/R8: channel 0 two-byte, mode code 111
        cyc(0, 3, 1, 0, 8'h3E);
        cyc(0, 0, 1, 0, 8'h34);
        idle();
        cyc(0, 0, 1, 0, 8'h12);
        idle();
        // R9: read order per format
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 1, 0, 1, 0);
        cyc(0, 2, 0, 1, 0);
        // R6: control word mid-sequence restarts both toggles
        cyc(0, 0, 1, 0, 8'h77);
        cyc(0, 3, 1, 0, 8'h30);
        cyc(0, 0, 1, 0, 8'h11);
        cyc(0, 0, 1, 0, 8'h22);
        idle();
        // R4: latch command for channel 1
        cyc(0, 3, 1, 0, 8'h40);
        idle();
        idle();
        // R5: channel field 11 ignored
        cyc(0, 3, 1, 0, 8'hFE);
        idle();
        // R10: control offset read
        cyc(0, 3, 0, 1, 0);
        // R11/R12: auxiliary register
        out_last = 1'b1;
        cyc(1, 0, 1, 0, 8'h03);
        cyc(1, 0, 0, 1, 0);
        cyc(1, 2, 1, 0, 8'hFC);
        cyc(1, 1, 0, 1, 0);
        out_last = 1'b0;

        // Mixed traffic
        for (int n = 0; n < 400; n++) begin
            int op;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = int'(lfsr[2:0]);
            out_last = lfsr[9];
            cnt_in[int'(lfsr[4:3] % 3)*16 +: 16] = {lfsr[7:0], lfsr[15:8]};
            case (op)
                0: cyc(0, 3, 1, 0, {2'(lfsr[15:14] % 3), lfsr[13:8]});
                1: cyc(1, int'(lfsr[5:4]), 1, 0, int'(lfsr[15:8]));
                2, 3: cyc(0, int'(lfsr[5:4]), 1, 0, int'(lfsr[15:8]));
                4, 5: cyc(0, int'(lfsr[5:4]), 0, 1, 0);
                6: cyc(1, 0, 0, 1, 0);
                default: idle();
            endcase
        end
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule